// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a chip's system bus. Software reaches it through a small word-addressed register port clocked by the fast bus clock. The counting logic runs from a separate slow functional clock of about 32 kHz. Each write to a register that the slow side uses is posted across the clock boundary. A per-register pending flag stays set until the handshake for that write has completed.

The timer is a 32-bit up-counter. It starts only after the exact two-word start key and stops only after the exact two-word stop key. A single stray word cannot start or stop it. Software keeps the timer from expiring by writing a trigger value that differs from the previous one, and the usual practice is to alternate a pattern with its complement. When the counter wraps past all ones, the block drives a reset pulse of fixed length on its output and reloads the counter from the load register. An optional prescaler slows the count by a power of two.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is stopped. The load register, the counter and every pending flag are zero, and `wdt_rst_out` is low.
- R2: Address map (word index on `bus_addr`): 0 revision, 1 configuration, 2 control, 3 load, 4 counter, 5 trigger, 6 key, 7 pending. The revision register reads `REV_ID` in bits 7:0. Bit 0 of the configuration register reads back what was written. The control register reads back the last word accepted.
- R3: A write to control, load, trigger or key sets its pending flag in the next cycle. The flags sit at bit 0, bit 2, bit 3 and bit 4 of the pending register, in that order. The flag clears by itself once the value has been applied in the functional clock domain.
- R4: A write to a register whose pending flag is set is ignored.
- R5: A key write of 0xBBBB followed directly by a key write of 0x4444 starts the counter.
- R6: A key write of 0xAAAA followed directly by a key write of 0x5555 stops the counter. Any other word written between the two halves leaves the timer running.
- R7: A key word that does not complete an armed sequence discards the first half. For example, 0xBBBB, then 0x0000, then 0x4444 leaves the timer stopped.
- R8: A trigger write whose value differs from the previous trigger value reloads the counter from the load register, whether or not the timer runs. Repeating the same value has no effect. The previous trigger value after reset is 0.
- R9: While running, the counter increments once per tick. On the tick after 0xFFFFFFFF it reloads from the load register and starts a reset pulse. The pulses therefore repeat every 2^32 − load ticks.
- R10: When control bit 5 is 1, one tick occurs every 2^n functional cycles, where n is control bits 4:2. When bit 5 is 0, a tick occurs every functional cycle.
- R11: `wdt_rst_out` stays high for exactly `RST_CYCLES` functional clock cycles per wrap, and the pulse finishes even if the timer is stopped during it.
- R12: Writes to the revision, counter and pending registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset. It must span several functional clock edges |
| fclk | input | 1 | Slow functional clock for the counter |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_sel` |
| wdt_rst_out | output | 1 | Reset request pulse, functional clock domain |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` 1 ns after it drives the address. A pending flag is due one bus cycle after its write, and the bench reads it at the next falling edge. The time for a value to reach the slow domain depends on both clocks. Rather than predict a fixed cycle, the bench polls the pending register as software would, and checks the effect only after the flag has cleared. Pulse length and spacing are counted in functional clock edges, sampled 1 ns after each edge, and compared with `RST_CYCLES` and with 2^32 − load scaled by the prescale factor.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int DW    = 32;
    localparam int AW    = 3;
    localparam int NPOST = 4;
    localparam int PTV_W = 3;

    typedef enum logic [AW-1:0] {
        RA_REV   = 3'd0,
        RA_CFG   = 3'd1,
        RA_CTRL  = 3'd2,
        RA_LOAD  = 3'd3,
        RA_COUNT = 3'd4,
        RA_TRIG  = 3'd5,
        RA_KEY   = 3'd6,
        RA_PEND  = 3'd7
    } reg_addr_e;

    // posted channel indices
    localparam int CH_CTRL = 0;
    localparam int CH_LOAD = 1;
    localparam int CH_TRIG = 2;
    localparam int CH_KEY  = 3;

    localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
    localparam logic [15:0] KEY_ON_B  = 16'h4444;
    localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
    localparam logic [15:0] KEY_OFF_B = 16'h5555;

    typedef struct packed {
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
    } ctrl_t;

    typedef enum logic [1:0] {KS_IDLE, KS_ON_ARMED, KS_OFF_ARMED} key_st_e;

    typedef struct packed {
        key_st_e st;
        logic    run;
    } key_res_t;

    function automatic reg_addr_e chan_addr(input int ch);
        case (ch)
            CH_CTRL: return RA_CTRL;
            CH_LOAD: return RA_LOAD;
            CH_TRIG: return RA_TRIG;
            default: return RA_KEY;
        endcase
    endfunction

    // bit of the pending register owned by each channel
    function automatic int chan_pend_bit(input int ch);
        case (ch)
            CH_CTRL: return 0;
            CH_LOAD: return 2;
            CH_TRIG: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [DW-1:0] w);
        ctrl_t c;
        c.pre_en = w[5];
        c.ptv    = w[4:2];
        return c;
    endfunction

    // one step of the two-word key checker
    function automatic key_res_t key_step(input key_st_e st, input logic run,
                                          input logic [15:0] w);
        key_res_t r;
        r.st  = KS_IDLE;
        r.run = run;
        if (w == KEY_ON_A)                              r.st  = KS_ON_ARMED;
        else if (w == KEY_OFF_A)                        r.st  = KS_OFF_ARMED;
        else if (w == KEY_ON_B  && st == KS_ON_ARMED)   r.run = 1'b1;
        else if (w == KEY_OFF_B && st == KS_OFF_ARMED)  r.run = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/wdt_post_cdc.sv
`timescale 1ns/1ps
module wdt_post_cdc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fclk,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic [W-1:0] held,
    output logic         apply_f
);
    logic req, ack_s1, ack_s2;
    logic req_s1, req_s2, ack_f;

    assign busy = req | ack_s2;

    // bus side: capture, raise request, drop it once acknowledged
    always_ff @(posedge clk) begin
        if (rst) begin
            req    <= 1'b0;
            held   <= '0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack_f;
            ack_s2 <= ack_s1;
            if (wr_en && !busy) begin
                held <= wdata;
                req  <= 1'b1;
            end else if (req && ack_s2) begin
                req <= 1'b0;
            end
        end
    end

    // functional side: two-flop sync, ack follows request
    always_ff @(posedge fclk) begin
        if (rst) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            ack_f  <= 1'b0;
        end else begin
            req_s1 <= req;
            req_s2 <= req_s1;
            ack_f  <= req_s2;
        end
    end

    assign apply_f = req_s2 & ~ack_f;
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic             fclk,
    input  logic             rst,
    input  logic             ctrl_apply,
    input  ctrl_t            ctrl_in,
    input  logic             load_apply,
    input  logic [CNT_W-1:0] load_in,
    input  logic             trig_apply,
    input  logic [DW-1:0]    trig_in,
    input  logic             key_apply,
    input  logic [15:0]      key_in,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             wrap_tick,
    output logic             rst_pulse
);
    localparam int PRE_W = (1 << PTV_W) - 1;
    localparam int RC_W  = $clog2(RST_CYCLES + 1);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q, cnt_q;
    logic [DW-1:0]    trig_last_q;
    key_st_e          key_st_q;
    logic             run_q;
    logic [PRE_W-1:0] pre_q, pre_lim;
    logic [RC_W-1:0]  rc_q;
    logic             tick, trig_hit;
    key_res_t         key_res;

    always_comb begin
        pre_lim   = PRE_W'((32'd1 << ctrl_q.ptv) - 32'd1);
        tick      = run_q && (!ctrl_q.pre_en || pre_q == pre_lim);
        wrap_tick = tick && (cnt_q == '1);
        trig_hit  = trig_apply && (trig_in != trig_last_q);
        key_res   = key_step(key_st_q, run_q, key_in);
    end

    always_ff @(posedge fclk) begin
        if (rst) begin
            ctrl_q      <= '0;
            load_q      <= '0;
            cnt_q       <= '0;
            trig_last_q <= '0;
            key_st_q    <= KS_IDLE;
            run_q       <= 1'b0;
            pre_q       <= '0;
            rc_q        <= '0;
        end else begin
            if (ctrl_apply) begin
                ctrl_q <= ctrl_in;
                pre_q  <= '0;
            end else if (run_q) begin
                pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            end
            if (load_apply) load_q <= load_in;
            if (key_apply) begin
                key_st_q <= key_res.st;
                run_q    <= key_res.run;
            end
            if (trig_apply) trig_last_q <= trig_in;
            if (trig_hit || wrap_tick) cnt_q <= load_q;
            else if (tick)             cnt_q <= cnt_q + CNT_W'(1);
            if (wrap_tick)             rc_q <= RC_W'(RST_CYCLES);
            else if (rc_q != '0)       rc_q <= rc_q - RC_W'(1);
        end
    end

    assign count     = cnt_q;
    assign running   = run_q;
    assign rst_pulse = (rc_q != '0);
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter logic [7:0] REV_ID     = 8'h21,
    parameter int         RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fclk,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wdt_rst_out
);
    logic [DW-1:0]    post_held [NPOST];
    logic [NPOST-1:0] post_busy, post_apply, post_wr;
    logic [7:0]       pend_vec;
    logic             cfg_q;
    logic [DW-1:0]    count_f;
    logic             run_f, wrap_f;

    for (genvar g = 0; g < NPOST; g++) begin : g_post
        assign post_wr[g] = bus_sel && bus_wr && (bus_addr == chan_addr(g));
        wdt_post_cdc #(.W(DW)) u_post (
            .clk    (clk),
            .rst    (rst),
            .fclk   (fclk),
            .wr_en  (post_wr[g]),
            .wdata  (bus_wdata),
            .busy   (post_busy[g]),
            .held   (post_held[g]),
            .apply_f(post_apply[g])
        );
    end

    always_comb begin
        pend_vec = '0;
        for (int i = 0; i < NPOST; i++) pend_vec[chan_pend_bit(i)] = post_busy[i];
    end

    always_ff @(posedge clk) begin
        if (rst)                                          cfg_q <= 1'b0;
        else if (bus_sel && bus_wr && bus_addr == RA_CFG) cfg_q <= bus_wdata[0];
    end

    wdt_core #(.CNT_W(DW), .RST_CYCLES(RST_CYCLES)) u_core (
        .fclk      (fclk),
        .rst       (rst),
        .ctrl_apply(post_apply[CH_CTRL]),
        .ctrl_in   (ctrl_decode(post_held[CH_CTRL])),
        .load_apply(post_apply[CH_LOAD]),
        .load_in   (post_held[CH_LOAD]),
        .trig_apply(post_apply[CH_TRIG]),
        .trig_in   (post_held[CH_TRIG]),
        .key_apply (post_apply[CH_KEY]),
        .key_in    (post_held[CH_KEY][15:0]),
        .count     (count_f),
        .running   (run_f),
        .wrap_tick (wrap_f),
        .rst_pulse (wdt_rst_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                RA_REV:   bus_rdata = {24'h0, REV_ID};
                RA_CFG:   bus_rdata = {31'h0, cfg_q};
                RA_CTRL:  bus_rdata = post_held[CH_CTRL];
                RA_LOAD:  bus_rdata = post_held[CH_LOAD];
                RA_COUNT: bus_rdata = count_f;
                RA_TRIG:  bus_rdata = post_held[CH_TRIG];
                RA_KEY:   bus_rdata = post_held[CH_KEY];
                default:  bus_rdata = {24'h0, pend_vec};
            endcase
        end
    end
endmodule

// File: rtl/wdt_chk.sv
`timescale 1ns/1ps
module wdt_chk #(
    parameter int RST_CYCLES = 4
) (
    input logic        clk,
    input logic        fclk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [7:0]  pend,
    input logic [31:0] load_held,
    input logic        run_f,
    input logic [31:0] count_f,
    input logic        wrap_f,
    input logic        rst_out,
    input logic        key_apply,
    input logic [15:0] key_word
);
    logic [31:0] hi_cnt;

    always_ff @(posedge fclk) begin
        if (rst)         hi_cnt <= '0;
        else if (wrap_f) hi_cnt <= '0;
        else             hi_cnt <= rst_out ? hi_cnt + 32'd1 : 32'd0;
    end

    // R1
    reset_pend_chk: assert property (@(posedge clk) rst |=> (pend == 8'h00));

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd5 && !pend[3]) |=> pend[3]);

    // R4
    held_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd3 && pend[2]) |=> $stable(load_held));

    // R5
    start_key_chk: assert property (@(posedge fclk) disable iff (rst)
        $rose(run_f) |-> $past(key_apply && key_word == 16'h4444));

    // R6
    stop_key_chk: assert property (@(posedge fclk) disable iff (rst)
        $fell(run_f) |-> $past(key_apply && key_word == 16'h5555));

    // R9
    wrap_src_chk: assert property (@(posedge fclk) disable iff (rst)
        $rose(rst_out) |-> $past(count_f == 32'hFFFF_FFFF));

    // R11
    pulse_len_chk: assert property (@(posedge fclk) disable iff (rst)
        $fell(rst_out) |-> (hi_cnt == 32'(RST_CYCLES)));
endmodule

bind keyed_wdt wdt_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk      (clk),
    .fclk     (fclk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pend     (pend_vec),
    .load_held(post_held[1]),
    .run_f    (run_f),
    .count_f  (count_f),
    .wrap_f   (wrap_f),
    .rst_out  (wdt_rst_out),
    .key_apply(post_apply[3]),
    .key_word (post_held[3][15:0])
);

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
    localparam int RSTC = 4;
    localparam logic [2:0] A_REV = 3'd0, A_CFG = 3'd1, A_CTRL = 3'd2, A_LOAD = 3'd3,
                           A_CNT = 3'd4, A_TRIG = 3'd5, A_KEY = 3'd6, A_PEND = 3'd7;
    localparam logic [31:0] M_CTRL = 32'h01, M_LOAD = 32'h04, M_TRIG = 32'h08, M_KEY = 32'h10;

    logic        clk = 0, fclk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_out;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always #35 fclk = ~fclk;

    keyed_wdt #(.REV_ID(8'h21), .RST_CYCLES(RSTC)) u_keyed_wdt (
        .clk(clk), .rst(rst), .fclk(fclk), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_out(wdt_rst_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wait_idle(input logic [31:0] mask);
        logic [31:0] v;
        int n = 0;
        do begin
            bus_read(A_PEND, v);
            n++;
        end while ((v & mask) != 0 && n < 1000);
        if (n >= 1000) check("R3", "pending flag never cleared", v & mask, 32'h0);
    endtask

    task automatic post(input logic [2:0] a, input logic [31:0] d, input logic [31:0] m);
        bus_write(a, d);
        wait_idle(m);
    endtask

    task automatic fstep();
        @(posedge fclk);
        #1;
    endtask

    // width and period of the next full reset pulse, in functional cycles
    task automatic measure(output int w, output int p);
        int g = 0;
        w = 0; p = 0;
        while (wdt_rst_out && g < 500) begin fstep(); g++; end
        while (!wdt_rst_out && g < 1000) begin fstep(); g++; end
        while (wdt_rst_out && p < 500) begin fstep(); w++; p++; end
        while (!wdt_rst_out && p < 500) begin fstep(); p++; end
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin fstep(); if (wdt_rst_out) hi++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int w, p, hi;
        repeat (30) @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_read(A_PEND, v);  check("R1", "pending after reset", v, 32'h0);
        bus_read(A_LOAD, v);  check("R1", "load after reset", v, 32'h0);
        bus_read(A_CNT, v);   check("R1", "counter after reset", v, 32'h0);
        check("R1", "reset out idle", {31'h0, wdt_rst_out}, 32'h0);

        // R2 revision and configuration
        bus_read(A_REV, v);   check("R2", "revision", v & 32'hFF, 32'h21);
        bus_write(A_CFG, 32'h1);
        bus_read(A_CFG, v);   check("R2", "config bit0", v, 32'h1);

        // R3 pending flag sets next cycle then clears
        bus_write(A_LOAD, 32'h0000_1000);
        bus_read(A_PEND, v);  check("R3", "load pending bit2", v & M_LOAD, M_LOAD);
        wait_idle(M_LOAD);
        bus_read(A_PEND, v);  check("R3", "load pending cleared", v, 32'h0);

        // R4 write while pending is dropped
        bus_write(A_LOAD, 32'h0000_3000);
        bus_write(A_LOAD, 32'h0000_4000);
        wait_idle(M_LOAD);
        bus_read(A_LOAD, v);  check("R4", "second load ignored", v, 32'h0000_3000);
        post(A_LOAD, 32'h0000_1000, M_LOAD);

        // R8 trigger reload behaviour while stopped
        bus_write(A_TRIG, 32'h1234);
        bus_read(A_PEND, v);  check("R3", "trigger pending bit3", v & M_TRIG, M_TRIG);
        wait_idle(M_TRIG);
        bus_read(A_CNT, v);   check("R8", "reload on new trigger", v, 32'h0000_1000);
        post(A_LOAD, 32'h0000_2000, M_LOAD);
        post(A_TRIG, 32'h1234, M_TRIG);
        bus_read(A_CNT, v);   check("R8", "same trigger ignored", v, 32'h0000_1000);
        post(A_TRIG, 32'hEDCB, M_TRIG);
        bus_read(A_CNT, v);   check("R8", "complement trigger reloads", v, 32'h0000_2000);

        // R5 start, R9 wrap period, R11 width
        post(A_LOAD, 32'hFFFF_FFF0, M_LOAD);
        post(A_TRIG, 32'h1234, M_TRIG);
        bus_read(A_CNT, v);   check("R8", "reload near wrap", v, 32'hFFFF_FFF0);
        bus_write(A_KEY, 32'hBBBB);
        bus_read(A_PEND, v);  check("R3", "key pending bit4", v & M_KEY, M_KEY);
        wait_idle(M_KEY);
        post(A_KEY, 32'h4444, M_KEY);
        measure(w, p);
        check("R5", "timer started (pulse seen)", {31'h0, p > 0}, 32'h1);
        check("R11", "pulse width", w, RSTC);
        check("R9", "wrap period 2^32-load", p, 32'd16);

        // R6 stop key with a stray word in between keeps running
        post(A_KEY, 32'hAAAA, M_KEY);
        post(A_KEY, 32'h1111, M_KEY);
        post(A_KEY, 32'h5555, M_KEY);
        measure(w, p);
        check("R6", "broken stop keeps period", p, 32'd16);

        // R6 proper stop
        post(A_KEY, 32'hAAAA, M_KEY);
        post(A_KEY, 32'h5555, M_KEY);
        repeat (RSTC + 2) fstep();
        count_high(40, hi);   check("R6", "no pulse after stop", hi, 32'd0);
        bus_read(A_CNT, v);
        repeat (100) @(negedge clk);
        bus_read(A_CNT, v2);  check("R6", "counter frozen", v2, v);

        // R7 broken start sequence
        post(A_KEY, 32'hBBBB, M_KEY);
        post(A_KEY, 32'h0000, M_KEY);
        post(A_KEY, 32'h4444, M_KEY);
        bus_read(A_CNT, v);
        count_high(40, hi);   check("R7", "no pulse after broken start", hi, 32'd0);
        bus_read(A_CNT, v2);  check("R7", "counter still frozen", v2, v);

        // R10 prescaler divide by 2
        post(A_CTRL, 32'h24, M_CTRL);
        bus_read(A_CTRL, v);  check("R2", "control readback", v, 32'h24);
        post(A_TRIG, 32'hEDCB, M_TRIG);
        post(A_KEY, 32'hBBBB, M_KEY);
        post(A_KEY, 32'h4444, M_KEY);
        measure(w, p);
        check("R10", "prescaled period", p, 32'd32);
        check("R11", "width with prescaler", w, RSTC);

        // R10 prescaler off again
        post(A_CTRL, 32'h04, M_CTRL);
        measure(w, p);
        measure(w, p);
        check("R10", "prescaler disabled period", p, 32'd16);

        // R12 read-only registers ignore writes
        post(A_KEY, 32'hAAAA, M_KEY);
        post(A_KEY, 32'h5555, M_KEY);
        repeat (RSTC + 2) fstep();
        bus_read(A_CNT, v);
        bus_write(A_CNT, 32'hDEAD_BEEF);
        bus_read(A_CNT, v2);  check("R12", "counter write ignored", v2, v);
        bus_write(A_REV, 32'h0000_00FF);
        bus_read(A_REV, v);   check("R12", "revision write ignored", v & 32'hFF, 32'h21);
        bus_write(A_PEND, 32'hFFFF_FFFF);
        bus_read(A_PEND, v);  check("R12", "pending write ignored", v, 32'h0);

        finish_run();
    end
endmodule